// File: doc/BRIEF.md
# Coalescing Store Queue with Load Forwarding

This block sits between a write-through cache and a slow memory port. It takes CPU stores and parks them in a small set of block-sized slots, so the processor keeps running while memory catches up. Before a store takes a new slot, every slot that is waiting is searched at once by block address. A store to a block that is already waiting is folded into that slot, byte by byte. Slots are then written to memory one at a time, the oldest first. The byte-valid mask of the slot goes out as the byte enables.

Loads search the same slots. When the youngest matching slot holds every byte of the requested word, the word is returned from the buffer in the same cycle. When no slot matches, the load's read request goes straight to the shared memory port and takes it ahead of any write-back. When a slot matches but lacks some of the bytes, the load waits while the buffer empties in age order. Once no slot holds the block, the load goes to memory. A store and a load offered in the same cycle both see the slot contents from before that cycle.

Top module: `wb_coalesce`

## Requirements
- R1: After reset the buffer is empty: `st_ready` is 1, `mem_req` is 0 and `ld_hit` is 0.
- R2: A store accepted into an empty buffer shows up as a memory write request (`mem_req`=1, `mem_we`=1) in the cycle after acceptance. The request carries its block, its data in lane `st_word` (bits 32*w+31..32*w) and enables `st_be` shifted to bits 4*w+3..4*w of `mem_be`.
- R3: Stores to different words of a block that is waiting, and not being written out, are merged into one slot. Memory then sees a single write whose enables are the union of their byte enables.
- R4: Repeated stores to the same bytes of a waiting slot overwrite it, so only the last value reaches memory.
- R5: A load whose youngest matching slot has all 4 bytes of `ld_word` valid gets `ld_hit`=1, `ld_ready`=1 and that word on `ld_data` in the same cycle, with no memory read request.
- R6: A load that matches no slot raises a memory read (`mem_req`=1, `mem_we`=0, `mem_blk`=`ld_blk`) ahead of any pending write. `ld_ready` equals `mem_gnt`.
- R7: A load whose youngest matching slot lacks any requested byte holds `ld_ready` low while slots drain in age order. In the cycle after the last matching slot leaves, it is issued as a memory read.
- R8: Slots are written to memory oldest first, one per cycle in which `mem_gnt` is 1, and no write is issued beyond those stored.
- R9: With all slots full, a store to a block with no eligible slot sees `st_ready`=0. It is accepted anyway when it merges, or when the oldest slot finishes its write in that cycle.
- R10: The slot currently offered to memory cannot take merges. A store to its block takes a new slot, and two writes reach memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store accepted this cycle |
| st_blk | input | BLK_W | Block address of the store |
| st_word | input | log2(WORDS) | Word within the block |
| st_be | input | 4 | Byte enables within the word |
| st_data | input | 32 | Store data |
| ld_valid | input | 1 | Load offered |
| ld_ready | output | 1 | Load served or sent to memory this cycle |
| ld_blk | input | BLK_W | Block address of the load |
| ld_word | input | log2(WORDS) | Word within the block |
| ld_hit | output | 1 | Load served from the buffer |
| ld_data | output | 32 | Forwarded word, valid with ld_hit |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write-back, 0 = read |
| mem_gnt | input | 1 | Memory takes the request this cycle |
| mem_blk | output | BLK_W | Block address to memory |
| mem_be | output | 4*WORDS | Byte enables of a write-back |
| mem_wdata | output | 32*WORDS | Line data of a write-back |

## Verification
Load results (`ld_hit`, `ld_data`, `ld_ready`) and the read request are combinational, so they are checked one time unit after the inputs change in the same cycle. A store is visible to lookups and to the memory port only from the cycle after the edge that accepts it, so drain checks sample one cycle later. A write-back completes at the edge where `mem_gnt` is high. A monitor samples `mem_req`/`mem_we`/`mem_gnt` between edges, pops the expected write that the stimulus queued, and compares only the enabled bytes.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = 4;

  typedef enum logic [1:0] {
    OP_IDLE,
    OP_READ,
    OP_DRAIN
  } mem_op_e;
endpackage

// File: rtl/wb_lookup.sv
// Associative search over all slots; the youngest eligible match wins.
module wb_lookup #(
  parameter int DEPTH = 4,
  parameter int BLK_W = 26,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][BLK_W-1:0] tags,
  input  logic [DEPTH-1:0]            elig,
  input  logic [PTR_W-1:0]            head,
  input  logic [BLK_W-1:0]            key,
  output logic                        hit,
  output logic [PTR_W-1:0]            idx
);
  logic [DEPTH-1:0] eq;
  logic [PTR_W-1:0] slot;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign eq[g] = elig[g] && (tags[g] == key);
    end
  endgenerate

  always_comb begin
    hit  = 1'b0;
    idx  = head;
    slot = head;
    for (int i = 0; i < DEPTH; i++) begin
      slot = head + PTR_W'(i);
      if (eq[slot]) begin
        hit = 1'b1;
        idx = slot;
      end
    end
  end
endmodule

// File: rtl/wb_mem_arb.sv
// Shares the memory port: a missing load reads first, else the oldest slot drains.
module wb_mem_arb #(
  parameter int BLK_W  = 26,
  parameter int LINE_W = 128,
  parameter int BE_W   = 16
) (
  input  logic              ld_miss,
  input  logic [BLK_W-1:0]  ld_blk,
  input  logic              pend,
  input  logic [BLK_W-1:0]  head_blk,
  input  logic [LINE_W-1:0] head_line,
  input  logic [BE_W-1:0]   head_mask,
  input  logic              mem_gnt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [BLK_W-1:0]  mem_blk,
  output logic [BE_W-1:0]   mem_be,
  output logic [LINE_W-1:0] mem_wdata,
  output logic              draining,
  output logic              drain_done
);
  import wbuf_pkg::*;
  mem_op_e op;

  always_comb begin
    if (ld_miss)   op = OP_READ;
    else if (pend) op = OP_DRAIN;
    else           op = OP_IDLE;
  end

  assign draining   = (op == OP_DRAIN);
  assign drain_done = draining && mem_gnt;
  assign mem_req    = (op != OP_IDLE);
  assign mem_we     = draining;
  assign mem_blk    = (op == OP_READ) ? ld_blk : head_blk;
  assign mem_be     = draining ? head_mask : '0;
  assign mem_wdata  = draining ? head_line : '0;
endmodule

// File: rtl/wb_coalesce.sv
module wb_coalesce #(
  parameter int BLK_W = 26,
  parameter int WORDS = 4,
  parameter int DEPTH = 4,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int LINE_W = WORDS * wbuf_pkg::WORD_W,
  localparam int BE_W   = WORDS * wbuf_pkg::LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [BLK_W-1:0]  st_blk,
  input  logic [WSEL_W-1:0] st_word,
  input  logic [3:0]        st_be,
  input  logic [31:0]       st_data,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [BLK_W-1:0]  ld_blk,
  input  logic [WSEL_W-1:0] ld_word,
  output logic              ld_hit,
  output logic [31:0]       ld_data,
  output logic              mem_req,
  output logic              mem_we,
  input  logic              mem_gnt,
  output logic [BLK_W-1:0]  mem_blk,
  output logic [BE_W-1:0]   mem_be,
  output logic [LINE_W-1:0] mem_wdata
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  function automatic logic [LINE_W-1:0] put_word(logic [LINE_W-1:0] line,
      logic [WSEL_W-1:0] w, logic [3:0] be, logic [31:0] d);
    logic [LINE_W-1:0] r;
    r = line;
    for (int b = 0; b < 4; b++)
      if (be[b]) r[w*32 + b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [BE_W-1:0] put_mask(logic [BE_W-1:0] m,
      logic [WSEL_W-1:0] w, logic [3:0] be);
    logic [BE_W-1:0] r;
    r = m;
    r[w*4 +: 4] = m[w*4 +: 4] | be;
    return r;
  endfunction

  logic [DEPTH-1:0][BLK_W-1:0]  tag_q;
  logic [DEPTH-1:0][LINE_W-1:0] line_q;
  logic [DEPTH-1:0][BE_W-1:0]   mask_q;
  logic [PTR_W-1:0] head_q;
  logic [CNT_W-1:0] cnt_q;

  logic [DEPTH-1:0] live, st_elig;
  logic st_hit, ld_match, ld_cover, ld_part, ld_miss;
  logic [PTR_W-1:0] st_idx, ld_idx, tail;
  logic draining, drain_done, full, st_fire, st_merge, st_alloc;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_live
      logic [PTR_W-1:0] age;
      assign age        = PTR_W'(g) - head_q;
      assign live[g]    = {1'b0, age} < cnt_q;
      assign st_elig[g] = live[g] && !(draining && (PTR_W'(g) == head_q));
    end
  endgenerate

  wb_lookup #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_st_look (
    .tags(tag_q), .elig(st_elig), .head(head_q), .key(st_blk),
    .hit(st_hit), .idx(st_idx));

  wb_lookup #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_ld_look (
    .tags(tag_q), .elig(live), .head(head_q), .key(ld_blk),
    .hit(ld_match), .idx(ld_idx));

  assign ld_cover = (mask_q[ld_idx][ld_word*4 +: 4] == 4'hF);
  assign ld_hit   = ld_valid && ld_match && ld_cover;
  assign ld_part  = ld_valid && ld_match && !ld_cover;
  assign ld_miss  = ld_valid && !ld_match;
  assign ld_data  = line_q[ld_idx][ld_word*32 +: 32];

  wb_mem_arb #(.BLK_W(BLK_W), .LINE_W(LINE_W), .BE_W(BE_W)) u_arb (
    .ld_miss(ld_miss), .ld_blk(ld_blk), .pend(cnt_q != '0),
    .head_blk(tag_q[head_q]), .head_line(line_q[head_q]),
    .head_mask(mask_q[head_q]), .mem_gnt(mem_gnt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_blk(mem_blk),
    .mem_be(mem_be), .mem_wdata(mem_wdata),
    .draining(draining), .drain_done(drain_done));

  assign ld_ready = ld_hit || (ld_miss && mem_gnt);
  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign st_ready = st_hit || !full || drain_done;
  assign st_fire  = st_valid && st_ready;
  assign st_merge = st_fire && st_hit;
  assign st_alloc = st_fire && !st_hit;
  assign tail     = head_q + cnt_q[PTR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i]  <= '0;
        line_q[i] <= '0;
        mask_q[i] <= '0;
      end
    end else begin
      if (st_alloc) begin
        tag_q[tail]  <= st_blk;
        line_q[tail] <= put_word('0, st_word, st_be, st_data);
        mask_q[tail] <= put_mask('0, st_word, st_be);
      end else if (st_merge) begin
        line_q[st_idx] <= put_word(line_q[st_idx], st_word, st_be, st_data);
        mask_q[st_idx] <= put_mask(mask_q[st_idx], st_word, st_be);
      end
      if (drain_done) head_q <= head_q + 1'b1;
      if (st_alloc && !drain_done)      cnt_q <= cnt_q + 1'b1;
      else if (!st_alloc && drain_done) cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  assert_full_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (cnt_q == $past(cnt_q)));
  assert_read_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_miss |-> (mem_req && !mem_we && mem_blk == ld_blk));
  assert_hit_local_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |-> !(mem_req && !mem_we));
  assert_partial_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_part |-> (!ld_ready && mem_req && mem_we));
  assert_drain_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be != '0));
  assert_merge_keeps_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_merge && !drain_done) |=> (cnt_q == $past(cnt_q)));
  assert_no_merge_draining_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_merge && draining) |-> (st_idx != head_q));
endmodule

// File: tb/tb_wb_coalesce.sv
module tb_wb_coalesce;
  localparam int BLK_W = 26;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, st_valid, st_ready, ld_valid, ld_ready, ld_hit;
  logic mem_req, mem_we, mem_gnt;
  logic [BLK_W-1:0] st_blk, ld_blk, mem_blk;
  logic [1:0] st_word, ld_word;
  logic [3:0] st_be;
  logic [31:0] st_data, ld_data;
  logic [15:0] mem_be;
  logic [127:0] mem_wdata;

  wb_coalesce #(.BLK_W(BLK_W), .WORDS(4), .DEPTH(4)) dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_blk(st_blk), .st_word(st_word), .st_be(st_be), .st_data(st_data),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_blk(ld_blk),
    .ld_word(ld_word), .ld_hit(ld_hit), .ld_data(ld_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt),
    .mem_blk(mem_blk), .mem_be(mem_be), .mem_wdata(mem_wdata));

  typedef struct {
    logic [BLK_W-1:0] blk;
    logic [15:0]      be;
    logic [127:0]     data;
  } wr_t;

  wr_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push_wr(input logic [BLK_W-1:0] b, input logic [15:0] be,
                         input logic [127:0] d);
    wr_t e;
    e.blk = b; e.be = be; e.data = d;
    exp_q.push_back(e);
  endtask

  task automatic put_store(input logic [BLK_W-1:0] b, input logic [1:0] w,
                           input logic [3:0] be, input logic [31:0] d);
    st_valid = 1'b1; st_blk = b; st_word = w; st_be = be; st_data = d;
  endtask

  task automatic put_load(input logic [BLK_W-1:0] b, input logic [1:0] w);
    ld_valid = 1'b1; ld_blk = b; ld_word = w;
  endtask

  // Monitor: every completed write-back is compared in order (R8).
  initial begin
    wr_t e;
    logic [127:0] m;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && mem_req && mem_we && mem_gnt) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected write blk", 128'(mem_blk), 128'h0);
        end else begin
          e = exp_q.pop_front();
          m = '0;
          for (int b = 0; b < 16; b++) if (e.be[b]) m[b*8 +: 8] = 8'hFF;
          check(mem_blk == e.blk, "R8", "write blk", 128'(mem_blk), 128'(e.blk));
          check(mem_be == e.be, "R3", "write enables", 128'(mem_be), 128'(e.be));
          check((mem_wdata & m) == (e.data & m), "R4", "write data",
                mem_wdata & m, e.data & m);
        end
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    check(1'b0, "WDOG", "watchdog expired", 128'h0, 128'h1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; st_valid = 1'b0; ld_valid = 1'b0; mem_gnt = 1'b1;
    st_blk = '0; st_word = '0; st_be = '0; st_data = '0;
    ld_blk = '0; ld_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(st_ready == 1'b1, "R1", "st_ready after reset", 128'(st_ready), 128'h1);
    check(mem_req == 1'b0, "R1", "mem_req after reset", 128'(mem_req), 128'h0);
    check(ld_hit == 1'b0, "R1", "ld_hit after reset", 128'(ld_hit), 128'h0);

    // R2: single store drains next cycle
    @(negedge clk);
    put_store(26'h10, 2'd1, 4'hF, 32'hAABBCCDD);
    push_wr(26'h10, 16'h00F0, {64'h0, 32'hAABBCCDD, 32'h0});
    #1 check(st_ready, "R2", "store accepted", 128'(st_ready), 128'h1);
    @(negedge clk);
    st_valid = 1'b0;
    #1 check(mem_req && mem_we && mem_blk == 26'h10, "R2", "drain request blk",
             128'(mem_blk), 128'h10);
    repeat (2) @(negedge clk);
    #1 check(!mem_req, "R8", "idle after drain", 128'(mem_req), 128'h0);

    // R3/R4/R10 merge, overwrite and draining-slot exclusion, with mem held off
    @(negedge clk);
    mem_gnt = 1'b0;
    put_store(26'h20, 2'd0, 4'hF, 32'h1);
    @(negedge clk); put_store(26'h30, 2'd2, 4'h3, 32'h11112222);
    @(negedge clk); put_store(26'h30, 2'd2, 4'hC, 32'h33334444);
    #1 check(st_ready, "R3", "merge accepted", 128'(st_ready), 128'h1);
    @(negedge clk); put_store(26'h30, 2'd3, 4'hF, 32'h55);
    @(negedge clk); put_store(26'h30, 2'd3, 4'hF, 32'h66);
    @(negedge clk); put_store(26'h20, 2'd1, 4'hF, 32'h77);
    #1 check(st_ready, "R10", "store to draining block accepted", 128'(st_ready), 128'h1);
    @(negedge clk);
    st_valid = 1'b0;
    put_load(26'h30, 2'd3);
    #1;
    check(ld_hit && ld_ready, "R5", "full hit flags", 128'({ld_hit, ld_ready}), 128'h3);
    check(ld_data == 32'h66, "R4", "forwarded last value", 128'(ld_data), 128'h66);
    check(mem_req && mem_we, "R5", "no read on hit", 128'(mem_we), 128'h1);
    @(negedge clk);
    put_load(26'h30, 2'd2);
    #1 check(ld_hit && ld_data == 32'h33332222, "R3", "merged word forwarded",
             128'(ld_data), 128'h33332222);
    @(negedge clk);
    put_load(26'h20, 2'd0);
    #1 check(!ld_ready && !ld_hit && mem_we, "R7", "partial hit waits",
             128'({ld_ready, ld_hit, mem_we}), 128'h1);
    @(negedge clk);
    put_load(26'h40, 2'd0);
    #1 check(mem_req && !mem_we && mem_blk == 26'h40 && !ld_ready, "R6",
             "read ahead of drain", 128'({mem_req, mem_we, mem_blk}),
             128'({1'b1, 1'b0, 26'h40}));
    @(negedge clk);
    ld_valid = 1'b0;
    push_wr(26'h20, 16'h000F, {96'h0, 32'h1});
    push_wr(26'h30, 16'hFF00, {32'h66, 32'h33332222, 64'h0});
    push_wr(26'h20, 16'h00F0, {64'h0, 32'h77, 32'h0});
    mem_gnt = 1'b1;
    repeat (5) @(negedge clk);

    // R7: partial hit drains then reads
    mem_gnt = 1'b0;
    put_store(26'h50, 2'd0, 4'h1, 32'hEE);
    push_wr(26'h50, 16'h0001, {96'h0, 32'hEE});
    @(negedge clk);
    st_valid = 1'b0;
    mem_gnt = 1'b1;
    put_load(26'h50, 2'd0);
    #1 check(!ld_ready && mem_req && mem_we, "R7", "drain before read",
             128'({ld_ready, mem_we}), 128'h1);
    @(negedge clk);
    #1 check(mem_req && !mem_we && mem_blk == 26'h50 && ld_ready, "R7",
             "read after drain", 128'({mem_we, ld_ready}), 128'h1);
    @(negedge clk);
    ld_valid = 1'b0;
    repeat (2) @(negedge clk);

    // R9: full buffer behaviour
    mem_gnt = 1'b0;
    for (int i = 0; i < 4; i++) begin
      put_store(26'h60 + 26'(i), 2'd0, 4'hF, 32'h600 + 32'(i));
      #1 check(st_ready, "R9", "fill store accepted", 128'(st_ready), 128'h1);
      @(negedge clk);
    end
    put_store(26'h64, 2'd0, 4'hF, 32'h640);
    #1 check(!st_ready, "R9", "full stall", 128'(st_ready), 128'h0);
    @(negedge clk);
    put_store(26'h62, 2'd1, 4'hF, 32'h621);
    #1 check(st_ready, "R9", "merge while full", 128'(st_ready), 128'h1);
    @(negedge clk);
    push_wr(26'h60, 16'h000F, {96'h0, 32'h600});
    push_wr(26'h61, 16'h000F, {96'h0, 32'h601});
    push_wr(26'h62, 16'h00FF, {64'h0, 32'h621, 32'h602});
    push_wr(26'h63, 16'h000F, {96'h0, 32'h603});
    push_wr(26'h65, 16'h000F, {96'h0, 32'h650});
    put_store(26'h65, 2'd0, 4'hF, 32'h650);
    mem_gnt = 1'b1;
    #1 check(st_ready, "R9", "accept on drain completion", 128'(st_ready), 128'h1);
    @(negedge clk);
    st_valid = 1'b0;
    repeat (8) @(negedge clk);
    #1 check(!mem_req, "R8", "empty at end", 128'(mem_req), 128'h0);
    check(exp_q.size() == 0, "R8", "all writes seen", 128'(exp_q.size()), 128'h0);
    finish_run();
  end
endmodule